// File: doc/BRIEF.md
# Serial Flash Continuous-Read Mode Tracker

This block is the command front end of a serial flash device that supports execute-in-place reads over two or four data lines. It watches chip select and a per-cycle serial-clock strobe, samples the opcode, address and mode byte, and works out whether the next transaction opens with an 8-bit opcode or goes straight to its address. Its outputs are the decoded read command of the current transaction, the continuous-mode flag, and a one-cycle strobe that marks the start of the address phase.

All inputs are synchronous to `clk`. A cycle with `sck_en` high is one serial clock, and the data lines `io_in` are sampled in that cycle. The opcode moves one bit per clock on `io_in[0]`. The address and mode byte move two bits per clock on `io_in[1:0]` for the dual read, or four bits per clock on `io_in[3:0]` for the quad reads. Every field goes most significant part first. Only power-on clears the block. A host that restarts while the device is in continuous mode has to leave that mode with the all-ones exit pattern.

Top module: `xip_cont_read_tracker`

## Requirements
- R1: After power-on reset, `cont_mode` is 0, `read_cmd` is 0 (none) and `addr_start` is 0.
- R2: In normal mode, the first 8 clocks after chip select falls carry an opcode on `io_in[0]`, MSB first. Opcode BBh gives `read_cmd`=1 (two lines), EBh gives 2, E7h gives 3 and E3h gives 4 (all four lines). `addr_start` pulses in the cycle after the 8th clock is sampled.
- R3: Any other opcode gives no `addr_start`, leaves `read_cmd` at 0 for that transaction, and leaves `cont_mode` unchanged.
- R4: After a read opcode, the address takes ADDR_BITS/2 clocks (dual) or ADDR_BITS/4 clocks (quad). The mode byte M7..M0 follows in 4 or 2 clocks on the same lines, MSB first.
- R5: When chip select rises after a complete mode byte, `cont_mode` becomes 1 exactly when M5..M4 = binary 10. M7..M6 and M3..M0 have no effect.
- R6: In continuous mode, a transaction starts at the address phase, at the width of the latched command. `addr_start` pulses in the cycle after chip select is first sampled low, and `read_cmd` shows the latched command.
- R7: If chip select rises before the mode byte is complete, `cont_mode` and the latched command are left unchanged.
- R8: In quad continuous mode, 8 clocks with `io_in[0]` high clear `cont_mode`; 7 such clocks do not. In dual continuous mode, 16 clocks are needed; 8 do not clear it.
- R9: `cont_mode` changes only in the cycle after a rising edge of chip select. Idle clocks while chip select is high never change it.
- R10: `addr_start` is a single-cycle pulse, raised at most once per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cs_n | input | 1 | Chip select, active low |
| sck_en | input | 1 | Serial clock occurs in this cycle; `io_in` is sampled |
| io_in | input | 4 | Serial data lines 3..0 |
| read_cmd | output | 3 | Read command of the current transaction: 0 none, 1 dual, 2 quad, 3 word quad, 4 octal-word quad |
| cont_mode | output | 1 | Next transaction skips the opcode |
| addr_start | output | 1 | One-cycle strobe at the start of the address phase |

## Verification
The properties assume that chip select stays high for at least one cycle between transactions. They also assume no serial clock arrives in the first cycle chip select is low, because that cycle decides between the opcode path and the address path. The bench drives every transaction through one task, which lowers chip select one cycle before the first serial clock and raises it for two cycles afterwards. Serial clocks are never issued while chip select is high, except in the one idle-clock test aimed at R9. That test leaves a full idle gap before the next transaction begins.

// File: rtl/xip_trk_pkg.sv
package xip_trk_pkg;

  typedef enum logic [2:0] {
    RD_NONE      = 3'd0,
    RD_DUAL      = 3'd1,
    RD_QUAD      = 3'd2,
    RD_WORD_QUAD = 3'd3,
    RD_OCT_QUAD  = 3'd4
  } rd_cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INSTR,
    PH_ADDR,
    PH_MODE,
    PH_TAIL,
    PH_SKIP
  } phase_e;

  localparam int OPC_BITS  = 8;
  localparam int MODE_BITS = 8;

  function automatic logic uses_quad(rd_cmd_e c);
    return (c == RD_QUAD) || (c == RD_WORD_QUAD) || (c == RD_OCT_QUAD);
  endfunction

endpackage

// File: rtl/xip_op_decode.sv
module xip_op_decode
  import xip_trk_pkg::*;
(
  input  logic [7:0] opcode,
  output rd_cmd_e    cmd
);

  always_comb begin
    case (opcode)
      8'hBB:   cmd = RD_DUAL;
      8'hEB:   cmd = RD_QUAD;
      8'hE7:   cmd = RD_WORD_QUAD;
      8'hE3:   cmd = RD_OCT_QUAD;
      default: cmd = RD_NONE;
    endcase
  end

endmodule

// File: rtl/xip_phase_seq.sv
module xip_phase_seq
  import xip_trk_pkg::*;
#(
  parameter int ADDR_BITS = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck_en,
  input  logic [3:0] io_in,
  input  logic       cont_mode,
  input  rd_cmd_e    lat_cmd,
  output rd_cmd_e    cur_cmd,
  output logic       addr_start,
  output logic       mode_done,
  output logic [1:0] mode_sel
);

  localparam int ADDR_CLK_DUAL = ADDR_BITS / 2;
  localparam int ADDR_CLK_QUAD = ADDR_BITS / 4;
  localparam int CNT_W         = $clog2(ADDR_CLK_DUAL + OPC_BITS);
  // Seven bits suffice: the decoder appends the live bit, and the mode
  // decision needs only bits 5..4 of the finished byte.
  localparam int SR_W          = OPC_BITS - 1;

  localparam logic [CNT_W-1:0] OPC_LAST    = CNT_W'(OPC_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST_D = CNT_W'(ADDR_CLK_DUAL - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST_Q = CNT_W'(ADDR_CLK_QUAD - 1);
  localparam logic [CNT_W-1:0] MODE_LAST_D = CNT_W'(MODE_BITS / 2 - 1);
  localparam logic [CNT_W-1:0] MODE_LAST_Q = CNT_W'(MODE_BITS / 4 - 1);

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SR_W-1:0]   sr_q, sr_d;
  logic              quad_q, quad_d;
  rd_cmd_e           cur_q, cur_d;
  logic              stb_q, stb_d;
  rd_cmd_e           dec_cmd;
  logic [CNT_W-1:0]  addr_last, mode_last;
  logic [SR_W-1:0]   sr_wide;

  xip_op_decode u_dec (
    .opcode ({sr_q, io_in[0]}),
    .cmd    (dec_cmd)
  );

  always_comb begin
    addr_last = quad_q ? ADDR_LAST_Q : ADDR_LAST_D;
    mode_last = quad_q ? MODE_LAST_Q : MODE_LAST_D;
    sr_wide   = quad_q ? {sr_q[SR_W-5:0], io_in} : {sr_q[SR_W-3:0], io_in[1:0]};
  end

  // next-state process
  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    quad_d = quad_q;
    cur_d  = cur_q;
    stb_d  = 1'b0;
    if (cs_n) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          cnt_d = '0;
          if (cont_mode) begin
            ph_d   = PH_ADDR;
            cur_d  = lat_cmd;
            quad_d = uses_quad(lat_cmd);
            stb_d  = 1'b1;
          end else begin
            ph_d  = PH_INSTR;
            cur_d = RD_NONE;
          end
        end
        PH_INSTR: if (sck_en) begin
          sr_d  = {sr_q[SR_W-2:0], io_in[0]};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == OPC_LAST) begin
            cnt_d = '0;
            if (dec_cmd != RD_NONE) begin
              ph_d   = PH_ADDR;
              cur_d  = dec_cmd;
              quad_d = uses_quad(dec_cmd);
              stb_d  = 1'b1;
            end else begin
              ph_d = PH_SKIP;
            end
          end
        end
        PH_ADDR: if (sck_en) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == addr_last) begin
            cnt_d = '0;
            ph_d  = PH_MODE;
          end
        end
        PH_MODE: if (sck_en) begin
          sr_d  = sr_wide;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == mode_last) begin
            cnt_d = '0;
            ph_d  = PH_TAIL;
          end
        end
        default: ;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      sr_q   <= '0;
      quad_q <= 1'b0;
      cur_q  <= RD_NONE;
      stb_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
      quad_q <= quad_d;
      cur_q  <= cur_d;
      stb_q  <= stb_d;
    end
  end

  assign cur_cmd    = cur_q;
  assign addr_start = stb_q;
  assign mode_done  = (ph_q == PH_TAIL);
  assign mode_sel   = sr_q[5:4];

endmodule

// File: rtl/xip_mode_latch.sv
module xip_mode_latch
  import xip_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       mode_done,
  input  logic [1:0] mode_sel,
  input  rd_cmd_e    cur_cmd,
  output logic       cont_mode,
  output rd_cmd_e    lat_cmd
);

  logic    cs_q;
  logic    cont_q, cont_d;
  rd_cmd_e lat_q, lat_d;
  logic    upd_en;

  // Decision taken only when a transaction that finished its mode byte closes.
  assign upd_en = cs_n && !cs_q && mode_done;

  always_comb begin
    cont_d = cont_q;
    lat_d  = lat_q;
    if (upd_en) begin
      cont_d = (mode_sel == 2'b10);
      lat_d  = cur_cmd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      cont_q <= 1'b0;
      lat_q  <= RD_NONE;
    end else begin
      cs_q   <= cs_n;
      cont_q <= cont_d;
      lat_q  <= lat_d;
    end
  end

  assign cont_mode = cont_q;
  assign lat_cmd   = lat_q;

endmodule

// File: rtl/xip_cont_read_tracker.sv
module xip_cont_read_tracker
  import xip_trk_pkg::*;
#(
  parameter int ADDR_BITS = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck_en,
  input  logic [3:0] io_in,
  output logic [2:0] read_cmd,
  output logic       cont_mode,
  output logic       addr_start
);

  rd_cmd_e    cur_cmd, lat_cmd;
  logic       mode_done;
  logic [1:0] mode_sel;
  logic       cont_q;

  xip_phase_seq #(.ADDR_BITS(ADDR_BITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sck_en     (sck_en),
    .io_in      (io_in),
    .cont_mode  (cont_q),
    .lat_cmd    (lat_cmd),
    .cur_cmd    (cur_cmd),
    .addr_start (addr_start),
    .mode_done  (mode_done),
    .mode_sel   (mode_sel)
  );

  xip_mode_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .mode_done (mode_done),
    .mode_sel  (mode_sel),
    .cur_cmd   (cur_cmd),
    .cont_mode (cont_q),
    .lat_cmd   (lat_cmd)
  );

  assign read_cmd  = cur_cmd;
  assign cont_mode = cont_q;

endmodule

// File: rtl/xip_trk_checker.sv
module xip_trk_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [2:0] read_cmd,
  input logic       cont_mode,
  input logic       addr_start
);

  logic cs_d1, cs_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d1 <= 1'b1;
      cs_d2 <= 1'b1;
    end else begin
      cs_d1 <= cs_n;
      cs_d2 <= cs_d1;
    end
  end

  AST_FLAG_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cont_mode) |-> (cs_d1 && !cs_d2)); // R9

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_start |=> !addr_start); // R10

  AST_STROBE_HAS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_start |-> (read_cmd != 3'd0)); // R6

  AST_CMD_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    read_cmd <= 3'd4); // R2

  AST_STROBE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    addr_start |-> !cs_d1); // R6

endmodule

bind xip_cont_read_tracker xip_trk_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .read_cmd   (read_cmd),
  .cont_mode  (cont_mode),
  .addr_start (addr_start)
);

// File: tb/test_xip_cont_read_tracker.sv
module test_xip_cont_read_tracker;

  localparam int ADDR_BITS = 24;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sck_en;
  logic [3:0] io_in;
  logic [2:0] read_cmd;
  logic       cont_mode, addr_start;

  always #2 clk = ~clk;

  xip_cont_read_tracker #(.ADDR_BITS(ADDR_BITS)) i_xip_cont_read_tracker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_en(sck_en), .io_in(io_in),
    .read_cmd(read_cmd), .cont_mode(cont_mode), .addr_start(addr_start)
  );

  int         n_chk = 0;
  int         n_bad = 0;
  logic [3:0] stim [0:63];
  bit         exp_cont;
  logic [2:0] exp_lat;
  logic [7:0] rd_ops [4] = '{8'hBB, 8'hEB, 8'hE7, 8'hE3};
  logic [7:0] bad_ops [9] = '{8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hFF, 8'hBA, 8'hEA, 8'hE6, 8'h00};

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  function automatic logic [2:0] op_code(input logic [7:0] op);
    case (op)
      8'hBB:   return 3'd1;
      8'hEB:   return 3'd2;
      8'hE7:   return 3'd3;
      8'hE3:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic bit quad_of(input logic [2:0] c);
    return c >= 3'd2;
  endfunction

  task automatic fill_read(input bit with_op, input logic [7:0] op, input bit quad,
                           input logic [23:0] addr, input logic [7:0] mode,
                           input int tail, output int n);
    n = 0;
    if (with_op)
      for (int i = 0; i < 8; i++) begin stim[n] = {3'b000, op[7-i]}; n++; end
    if (quad) begin
      for (int i = 0; i < 6; i++) begin stim[n] = addr[23-4*i -: 4]; n++; end
      for (int i = 0; i < 2; i++) begin stim[n] = mode[7-4*i -: 4]; n++; end
    end else begin
      for (int i = 0; i < 12; i++) begin stim[n] = {2'b00, addr[23-2*i -: 2]}; n++; end
      for (int i = 0; i < 4; i++) begin stim[n] = {2'b00, mode[7-2*i -: 2]}; n++; end
    end
    for (int i = 0; i < tail; i++) begin stim[n] = 4'h0; n++; end
  endtask

  task automatic fill_const(input logic [3:0] v, input int cnt);
    for (int i = 0; i < cnt; i++) stim[i] = v;
  endtask

  // One transaction of nclk serial clocks, with its expected outcome
  // worked out from the requirements.
  task automatic run_xfer(input int nclk, input string req);
    logic [2:0] exp_cur;
    logic [7:0] op, m;
    int         start, mfirst, mlen, pulses, pulse_at;
    bit         quad, done, was_cont;
    was_cont = exp_cont;
    op = '0;
    if (exp_cont) begin
      exp_cur = exp_lat;
      start   = 0;
    end else begin
      for (int i = 0; i < 8; i++) op = {op[6:0], stim[i][0]};
      exp_cur = (nclk >= 8) ? op_code(op) : 3'd0;
      start   = 8;
    end
    quad   = quad_of(exp_cur);
    mfirst = start + (quad ? ADDR_BITS / 4 : ADDR_BITS / 2);
    mlen   = quad ? 2 : 4;
    done   = (exp_cur != 3'd0) && (nclk >= mfirst + mlen);
    m = '0;
    if (done)
      for (int k = 0; k < mlen; k++)
        m = quad ? {m[3:0], stim[mfirst+k]} : {m[5:0], stim[mfirst+k][1:0]};

    @(negedge clk);
    cs_n   = 1'b0;
    sck_en = 1'b0;
    pulses   = 0;
    pulse_at = -1;
    for (int k = 0; k <= nclk; k++) begin
      @(negedge clk);
      if (addr_start) begin pulses++; pulse_at = k; end
      if (k < nclk) begin
        sck_en = 1'b1;
        io_in  = stim[k];
      end else begin
        sck_en = 1'b0;
        io_in  = 4'h0;
        cs_n   = 1'b1;
      end
    end
    @(negedge clk);
    if (addr_start) pulses++;

    check(req, "read command", int'(read_cmd), int'(exp_cur));
    check("R10", "strobe count", pulses, (exp_cur != 3'd0) ? 1 : 0);
    if (exp_cur != 3'd0)
      check(was_cont ? "R6" : "R2", "strobe position", pulse_at, start);
    if (done) begin
      exp_cont = (m[5:4] == 2'b10);
      exp_lat  = exp_cur;
    end
    check(req, "continuous flag", int'(cont_mode), int'(exp_cont));
  endtask

  initial begin
    int n;
    rst_n  = 1'b0;
    cs_n   = 1'b1;
    sck_en = 1'b0;
    io_in  = 4'h0;
    exp_cont = 1'b0;
    exp_lat  = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: power-on state
    check("R1", "flag after reset", int'(cont_mode), 0);
    check("R1", "command after reset", int'(read_cmd), 0);
    check("R1", "strobe after reset", int'(addr_start), 0);

    // R3: opcodes that are not continuous reads
    foreach (bad_ops[i]) begin
      fill_read(1'b1, bad_ops[i], 1'b1, 24'h123456, 8'h20, 2, n);
      run_xfer(n, "R3");
    end

    // R7: aborted before the mode byte ends, mode would have set the flag
    fill_read(1'b1, 8'hEB, 1'b1, 24'hABCDEF, 8'hA0, 0, n);
    run_xfer(15, "R7");

    // R5: enter quad continuous mode
    fill_read(1'b1, 8'hEB, 1'b1, 24'h00F00F, 8'h25, 2, n);
    run_xfer(n, "R5");

    // R9: serial clocks with chip select high leave the flag alone
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      sck_en = 1'b1;
      io_in  = 4'hF;
    end
    @(negedge clk);
    sck_en = 1'b0;
    io_in  = 4'h0;
    @(negedge clk);
    check("R9", "flag after idle clocks", int'(cont_mode), 1);

    // R7/R8: too-short all-ones pattern in quad mode
    fill_const(4'hF, 7);
    run_xfer(7, "R8");
    // R6: continuous read that keeps the mode
    fill_read(1'b0, 8'h00, 1'b1, 24'h5A5A5A, 8'hE9, 2, n);
    run_xfer(n, "R6");
    // R8: 8 clocks with only io_in[0] high leave quad mode
    fill_const(4'b0001, 8);
    run_xfer(8, "R8");

    // R8: dual mode needs 16 clocks
    fill_read(1'b1, 8'hBB, 1'b0, 24'h345678, 8'h2F, 1, n);
    run_xfer(n, "R5");
    fill_const(4'b0001, 8);
    run_xfer(8, "R8");
    fill_const(4'b1111, 16);
    run_xfer(16, "R8");

    // R4/R5/R6/R8: sweep every mode byte value for every read opcode
    for (int oi = 0; oi < 4; oi++) begin
      for (int mv = 0; mv < 256; mv++) begin
        logic [23:0] a;
        bit          q;
        q = quad_of(op_code(rd_ops[oi]));
        a = 24'(mv * 66051 + oi * 4097);
        if (exp_cont) begin
          fill_const(4'b0001, quad_of(exp_lat) ? 8 : 16);
          run_xfer(quad_of(exp_lat) ? 8 : 16, "R8");
        end
        fill_read(1'b1, rd_ops[oi], q, a, 8'(mv), oi, n);
        run_xfer(n, "R5");
        if (exp_cont) begin
          fill_read(1'b0, 8'h00, q, ~a, 8'(mv), 1, n);
          run_xfer(n, "R6");
          fill_const(4'b0001, q ? 8 : 16);
          run_xfer(q ? 8 : 16, "R8");
        end
      end
    end

    finish_up();
  end

endmodule